// File: doc/BRIEF.md
# Store-Coalescing Write Buffer

This block sits between a processor store port and the request side of an SDRAM controller. It keeps one pending entry of up to eight 32-bit words within an aligned 8-word block. It folds stores into that entry so that the memory sees fewer, longer transfers. A single-word store costs several times more memory cycles per byte than an 8-word burst, so coalescing directly raises memory throughput.

Two kinds of coalescing apply. Stores to the word most recently written into the entry are merged byte by byte. Stores to the next ascending word address are appended to the entry, which then forms a burst. Both kinds apply only to stores tagged as coalescable. An untagged store always leaves as a one-word transfer.

The entry is handed off as a burst in four cases:
- a store arrives that cannot join the entry;
- the flush input is raised;
- sixteen cycles pass with no accepted store;
- the store was untagged.

The burst carries the start word address, the length and the eight word lanes with their byte masks. While a burst is waiting at the output, the store port is held off.

The controller has three states, and every transition is driven by the next-state logic:
- **IDLE**: the entry is empty. A tagged store moves to COLLECT. An untagged store moves to SEND.
- **COLLECT**: the entry is open. It moves to SEND on flush, on a store that does not fit, or on the idle timeout. Otherwise it stays in COLLECT and keeps accepting.
- **SEND**: the burst is offered. It moves to IDLE when the handshake completes.

Top module: `wbg_top`

## Requirements
- R1: After reset, `bst_valid` is 0 and `wr_ready` is 1.
- R2: A tagged store to the same word address as the last word written into the open entry merges into that word. Byte masks are ORed, bytes with a set strobe take the new data, other bytes keep the old data, and the burst length does not change.
- R3: Tagged stores to ascending consecutive word addresses are gathered into one burst. `bst_addr` is the first word address and `bst_len` is the number of distinct words. Word lane k (data bits 32k+31..32k, mask bits 4k+3..4k) holds the word whose address has low three bits equal to k. Lanes not written carry mask 0.
- R4: A burst never spans an 8-word aligned block and never exceeds 8 words. A next-word store whose low three address bits are 0 is held off (`wr_ready` 0) and closes the entry instead of joining it.
- R5: A tagged store that is neither to the last written word nor to the next one closes the entry. It is held off until the burst is handed off and is then accepted as the start of a new entry. A store that fits is never held off while the entry is open.
- R6: An untagged store accepted in IDLE is offered as a one-word burst in the very next cycle. An untagged store arriving at an open entry first closes that entry.
- R7: With the entry open, a flush request makes `bst_valid` 1 in the next cycle. A store presented in that same cycle is held off. A flush while no entry is open has no effect.
- R8: If 16 consecutive clock edges pass with an open entry and no accepted store, the burst is offered after the 16th edge. A store accepted on that 16th edge restarts the count instead.
- R9: While `bst_valid` is 1 and `bst_ready` is 0, address, length, data and masks stay stable, and `wr_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Store request present |
| wr_ready | output | 1 | Store accepted on this edge when high with `wr_valid` |
| wr_addr | input | ADDR_W (16) | Store word address |
| wr_data | input | DATA_W (32) | Store data |
| wr_strb | input | DATA_W/8 (4) | Byte strobes of the store |
| wr_gather | input | 1 | Store may be merged or gathered |
| flush_req | input | 1 | Force the open entry out |
| bst_valid | output | 1 | Burst offered |
| bst_ready | input | 1 | Memory side takes the burst |
| bst_addr | output | ADDR_W (16) | First word address of the burst |
| bst_len | output | 4 | Words in the burst, 1 to 8 |
| bst_data | output | BEATS*DATA_W (256) | Word lanes by block offset |
| bst_mask | output | BEATS*DATA_W/8 (32) | Byte masks by lane |

## Verification
Two functions can claim the same cycle. A flush can coincide with a store that would otherwise join the entry. An idle timeout can expire on the very edge where a new store is accepted. Both collisions are set up directly. In the first, the store must see `wr_ready` low, and the burst must leave with its old length, followed by a new entry. In the second, the store must win: the burst is not offered, and it later leaves with both words. Random store streams also produce these collisions, and every handed-off burst is compared with a bench model built from the rules above.

// File: rtl/wbg_pkg.sv
package wbg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_SEND    = 2'd2
    } wbg_state_t;

endpackage

// File: rtl/wbg_idle_timer.sv
module wbg_idle_timer #(
    parameter int IDLE_LIMIT = 16,
    localparam int CNT_W = (IDLE_LIMIT > 1) ? $clog2(IDLE_LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic kick,
    output logic expired
);

    logic [CNT_W-1:0] cnt_q;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_LIMIT - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || kick) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign expired = run && (cnt_q == LAST);

    // R8: once the window runs out without a new store, the open entry must be left
    assert_timeout_leaves_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !kick) |=> !run);

endmodule

// File: rtl/wbg_lane.sv
module wbg_lane #(
    parameter int DATA_W = 32,
    localparam int NB = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NB-1:0]     wr_be,
    output logic [DATA_W-1:0] data,
    output logic [NB-1:0]     be
);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            data <= '0;
            be   <= '0;
        end else if (we) begin
            for (int b = 0; b < NB; b++) begin
                if (wr_be[b]) data[b*8 +: 8] <= wr_data[b*8 +: 8];
            end
            be <= be | wr_be;
        end
    end

    // R2: a merged store never drops a byte it wrote
    assert_merge_keeps_bytes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr) |=> ((be & $past(wr_be)) == $past(wr_be)));

endmodule

// File: rtl/wbg_ctrl.sv
module wbg_ctrl
    import wbg_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BEATS      = 8,
    parameter int IDLE_LIMIT = 16,
    localparam int OFF_W = $clog2(BEATS),
    localparam int LEN_W = $clog2(BEATS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_gather,
    input  logic              flush_req,
    output logic              wr_ready,
    output logic [BEATS-1:0]  lane_we,
    output logic              lane_clr,
    output logic              bst_valid,
    input  logic              bst_ready,
    output logic [ADDR_W-1:0] bst_addr,
    output logic [LEN_W-1:0]  bst_len
);

    wbg_state_t state_q, state_d;

    logic [ADDR_W-1:0] base_q, last_q;
    logic [LEN_W-1:0]  cnt_q;
    logic              gath_q;
    logic              accept, fits, same_word, next_word, expired, collecting;

    assign same_word  = (wr_addr == last_q);
    assign next_word  = (wr_addr == last_q + ADDR_W'(1)) &&
                        (wr_addr[OFF_W-1:0] != '0);
    assign fits       = wr_gather && gath_q && (same_word || next_word);
    assign collecting = (state_q == ST_COLLECT);

    wbg_idle_timer #(.IDLE_LIMIT(IDLE_LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (collecting),
        .kick    (accept),
        .expired (expired)
    );

    // next state and store-side acceptance
    always_comb begin
        state_d  = state_q;
        wr_ready = 1'b0;
        accept   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                wr_ready = 1'b1;
                accept   = wr_valid;
                if (accept) state_d = wr_gather ? ST_COLLECT : ST_SEND;
            end
            ST_COLLECT: begin
                if (flush_req) begin
                    state_d = ST_SEND;
                end else if (wr_valid && !fits) begin
                    state_d = ST_SEND;
                end else begin
                    wr_ready = 1'b1;
                    accept   = wr_valid;
                    if (!accept && expired) state_d = ST_SEND;
                end
            end
            ST_SEND: begin
                if (bst_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // entry bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            last_q <= '0;
            cnt_q  <= '0;
            gath_q <= 1'b0;
        end else if (accept) begin
            if (state_q == ST_IDLE) begin
                base_q <= wr_addr;
                last_q <= wr_addr;
                cnt_q  <= LEN_W'(1);
                gath_q <= wr_gather;
            end else if (!same_word) begin
                last_q <= wr_addr;
                cnt_q  <= cnt_q + LEN_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        bst_valid = (state_q == ST_SEND);
        bst_addr  = base_q;
        bst_len   = cnt_q;
        lane_clr  = (state_q == ST_SEND) && bst_ready;
    end

    for (genvar i = 0; i < BEATS; i++) begin : g_we
        assign lane_we[i] = accept && (wr_addr[OFF_W-1:0] == OFF_W'(i));
    end

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_valid && !bst_ready) |=> (bst_valid && $stable(bst_addr) && $stable(bst_len)));

    assert_no_store_while_offered_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bst_valid |-> !wr_ready);

    assert_len_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bst_valid |-> (bst_len >= LEN_W'(1) && bst_len <= LEN_W'(BEATS)));

    assert_untagged_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_valid && !gath_q) |-> (bst_len == LEN_W'(1)));

    assert_flush_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (collecting && flush_req) |=> bst_valid);

    assert_lane_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_we));

endmodule

// File: rtl/wbg_top.sv
module wbg_top #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int BEATS      = 8,
    parameter int IDLE_LIMIT = 16,
    localparam int NB    = DATA_W / 8,
    localparam int LEN_W = $clog2(BEATS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_valid,
    output logic                    wr_ready,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [NB-1:0]           wr_strb,
    input  logic                    wr_gather,
    input  logic                    flush_req,
    output logic                    bst_valid,
    input  logic                    bst_ready,
    output logic [ADDR_W-1:0]       bst_addr,
    output logic [LEN_W-1:0]        bst_len,
    output logic [BEATS*DATA_W-1:0] bst_data,
    output logic [BEATS*NB-1:0]     bst_mask
);

    logic [BEATS-1:0] lane_we;
    logic             lane_clr;

    wbg_ctrl #(
        .ADDR_W     (ADDR_W),
        .BEATS      (BEATS),
        .IDLE_LIMIT (IDLE_LIMIT)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_gather (wr_gather),
        .flush_req (flush_req),
        .wr_ready  (wr_ready),
        .lane_we   (lane_we),
        .lane_clr  (lane_clr),
        .bst_valid (bst_valid),
        .bst_ready (bst_ready),
        .bst_addr  (bst_addr),
        .bst_len   (bst_len)
    );

    for (genvar i = 0; i < BEATS; i++) begin : g_lane
        wbg_lane #(.DATA_W(DATA_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (lane_clr),
            .we      (lane_we[i]),
            .wr_data (wr_data),
            .wr_be   (wr_strb),
            .data    (bst_data[i*DATA_W +: DATA_W]),
            .be      (bst_mask[i*NB +: NB])
        );
    end

    assert_mask_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_valid && !bst_ready) |=> ($stable(bst_mask) && $stable(bst_data)));

endmodule

// File: tb/wbg_top_test.sv
module wbg_top_test;

    localparam int AW = 16;

    typedef struct packed {
        logic [15:0]  a;
        logic [3:0]   l;
        logic [255:0] d;
        logic [31:0]  m;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_valid = 1'b0;
    logic         wr_ready;
    logic [15:0]  wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [3:0]   wr_strb = '0;
    logic         wr_gather = 1'b0;
    logic         flush_req = 1'b0;
    logic         bst_valid;
    logic         bst_ready = 1'b0;
    logic [15:0]  bst_addr;
    logic [3:0]   bst_len;
    logic [255:0] bst_data;
    logic [31:0]  bst_mask;

    int n_chk = 0;
    int n_err = 0;
    bit mon_en = 1'b0;
    bit rnd_ready = 1'b0;

    always #4 clk = ~clk;

    wbg_top uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
        .wr_gather(wr_gather), .flush_req(flush_req), .bst_valid(bst_valid),
        .bst_ready(bst_ready), .bst_addr(bst_addr), .bst_len(bst_len),
        .bst_data(bst_data), .bst_mask(bst_mask)
    );

    task automatic chk(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s", msg);
        end
    endtask

    // ---------------- bench model ----------------
    exp_t         q[$];
    bit           m_open = 1'b0;
    bit           m_gath = 1'b0;
    logic [15:0]  m_base, m_last;
    logic [3:0]   m_cnt;
    int           m_idle = 0;
    logic [255:0] m_data = '0;
    logic [31:0]  m_mask = '0;

    function automatic bit m_fits(logic [15:0] a, logic g);
        return g && m_gath && ((a == m_last) || ((a == m_last + 16'd1) && (a[2:0] != 3'd0)));
    endfunction

    task automatic m_close();
        exp_t e;
        e.a = m_base; e.l = m_cnt; e.d = m_data; e.m = m_mask;
        q.push_back(e);
        m_open = 1'b0; m_data = '0; m_mask = '0; m_idle = 0;
    endtask

    task automatic m_apply(logic [15:0] a, logic [31:0] d, logic [3:0] s, logic g);
        int off;
        off = int'(a[2:0]);
        if (!m_open) begin
            m_base = a; m_last = a; m_cnt = 4'd1; m_gath = g;
        end else if (a != m_last) begin
            m_last = a; m_cnt = m_cnt + 4'd1;
        end
        for (int b = 0; b < 4; b++)
            if (s[b]) begin
                m_data[off*32 + b*8 +: 8] = d[b*8 +: 8];
                m_mask[off*4 + b] = 1'b1;
            end
        m_idle = 0;
        if (!g) m_close();
        else    m_open = 1'b1;
    endtask

    // ---------------- monitor: checks handoffs, predicts next edge ----------------
    bit           pv_valid = 1'b0, pv_ready = 1'b0;
    logic [15:0]  pv_addr;
    logic [3:0]   pv_len;
    logic [255:0] pv_data;
    logic [31:0]  pv_mask;

    always @(negedge clk) begin
        if (mon_en) begin
            if (pv_valid && !pv_ready)
                chk(bst_valid && bst_addr == pv_addr && bst_len == pv_len &&
                    bst_data == pv_data && bst_mask == pv_mask,
                    $sformatf("R9 held burst changed: addr %h len %0d exp addr %h len %0d",
                              bst_addr, bst_len, pv_addr, pv_len));
            if (bst_valid && bst_ready) begin
                if (q.size() == 0) begin
                    chk(1'b0, $sformatf("R3 unexpected burst addr %h len %0d exp none", bst_addr, bst_len));
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(bst_addr == e.a && bst_len == e.l,
                        $sformatf("R3 burst header addr %h len %0d exp addr %h len %0d",
                                  bst_addr, bst_len, e.a, e.l));
                    chk(bst_mask == e.m && bst_data == e.d,
                        $sformatf("R2 burst payload mask %h data %h exp mask %h data %h",
                                  bst_mask, bst_data, e.m, e.d));
                end
            end
            pv_valid = bst_valid; pv_ready = bst_ready; pv_addr = bst_addr;
            pv_len = bst_len; pv_data = bst_data; pv_mask = bst_mask;

            if (m_open) begin
                if (flush_req) begin
                    m_close();
                end else if (wr_valid && !m_fits(wr_addr, wr_gather)) begin
                    m_close();
                end else if (wr_valid) begin
                    chk(wr_ready, $sformatf("R5 fitting store held off: ready %b exp 1", wr_ready));
                    if (wr_ready) m_apply(wr_addr, wr_data, wr_strb, wr_gather);
                end else begin
                    m_idle++;
                    if (m_idle == 16) m_close();
                end
            end else if (wr_valid && wr_ready) begin
                m_apply(wr_addr, wr_data, wr_strb, wr_gather);
            end
        end
    end

    always @(posedge clk) begin
        if (rnd_ready) begin
            #1 bst_ready = ($urandom % 4) != 0;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic present(logic [15:0] a, logic [31:0] d, logic [3:0] s, logic g);
        wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_strb = s; wr_gather = g;
    endtask

    task automatic wait_accept();
        bit acc;
        do begin
            @(negedge clk);
            acc = wr_ready;
            @(posedge clk); #1;
        end while (!acc);
        wr_valid = 1'b0;
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d, logic [3:0] s, logic g);
        present(a, d, s, g);
        wait_accept();
    endtask

    task automatic flush_pulse();
        flush_req = 1'b1; tick(); flush_req = 1'b0;
    endtask

    task automatic drain();
        bst_ready = 1'b1;
        for (int i = 0; i < 6; i++) tick();
    endtask

    initial begin
        #1_000_000;
        chk(1'b0, "R9 watchdog expired: done 0 exp 1");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [15:0] cur;
        void'($urandom(32'd20240611));
        repeat (4) tick();
        rst_n = 1'b1;
        @(negedge clk);
        chk(bst_valid == 1'b0 && wr_ready == 1'b1,
            $sformatf("R1 reset state valid %b ready %b exp 0 1", bst_valid, wr_ready));
        mon_en = 1'b1;
        tick();

        // R2 merge into one word
        bst_ready = 1'b0;
        wr(16'h0010, 32'h11223344, 4'b0011, 1'b1);
        wr(16'h0010, 32'hAABBCCDD, 4'b0110, 1'b1);
        flush_pulse();
        @(negedge clk);
        chk(bst_valid, $sformatf("R7 flush did not offer: valid %b exp 1", bst_valid));
        chk(bst_len == 4'd1 && bst_data[31:0] == 32'h00BBCC44 && bst_mask[3:0] == 4'b0111,
            $sformatf("R2 merge len %0d data %h mask %b exp 1 00bbcc44 0111",
                      bst_len, bst_data[31:0], bst_mask[3:0]));
        drain();

        // R4 full block then next-block store
        for (int i = 0; i < 8; i++) wr(16'h0020 + 16'(i), 32'hC0DE0000 + 32'(i), 4'hF, 1'b1);
        present(16'h0028, 32'h28282828, 4'hF, 1'b1);
        @(negedge clk);
        chk(!wr_ready, $sformatf("R4 block crossing accepted: ready %b exp 0", wr_ready));
        tick();
        @(negedge clk);
        chk(bst_valid && bst_addr == 16'h0020 && bst_len == 4'd8,
            $sformatf("R4 full burst addr %h len %0d exp 0020 8", bst_addr, bst_len));
        wait_accept();
        flush_pulse();
        drain();

        // R3/R5 mid-block start then jump
        bst_ready = 1'b0;
        wr(16'h0033, 32'h33333333, 4'hF, 1'b1);
        wr(16'h0034, 32'h34343434, 4'hF, 1'b1);
        wr(16'h0035, 32'h35353535, 4'hF, 1'b1);
        present(16'h0050, 32'h50505050, 4'hF, 1'b1);
        @(negedge clk);
        chk(!wr_ready, $sformatf("R5 jump store accepted: ready %b exp 0", wr_ready));
        tick();
        @(negedge clk);
        chk(bst_valid && bst_addr == 16'h0033 && bst_len == 4'd3 && bst_mask == 32'h00FFF000,
            $sformatf("R3 partial burst addr %h len %0d mask %h exp 0033 3 00fff000",
                      bst_addr, bst_len, bst_mask));
        bst_ready = 1'b1;
        wait_accept();
        flush_pulse();
        drain();

        // R6 untagged stores
        wr(16'h00A0, 32'hA0A0A0A0, 4'hF, 1'b0);
        @(negedge clk);
        chk(bst_valid && bst_len == 4'd1 && bst_addr == 16'h00A0,
            $sformatf("R6 single beat valid %b len %0d addr %h exp 1 1 00a0", bst_valid, bst_len, bst_addr));
        drain();
        wr(16'h00B0, 32'hB0B0B0B0, 4'hF, 1'b1);
        wr(16'h00B1, 32'hB1B1B1B1, 4'hF, 1'b0);
        @(negedge clk);
        chk(bst_valid && bst_addr == 16'h00B1 && bst_len == 4'd1,
            $sformatf("R6 untagged after entry addr %h len %0d exp 00b1 1", bst_addr, bst_len));
        drain();

        // R7 flush and fitting store in the same cycle
        wr(16'h0090, 32'h90909090, 4'hF, 1'b1);
        flush_req = 1'b1;
        present(16'h0091, 32'h91919191, 4'hF, 1'b1);
        @(negedge clk);
        chk(!wr_ready, $sformatf("R7 store taken during flush: ready %b exp 0", wr_ready));
        tick();
        flush_req = 1'b0;
        @(negedge clk);
        chk(bst_valid && bst_len == 4'd1 && bst_addr == 16'h0090,
            $sformatf("R7 flushed burst len %0d addr %h exp 1 0090", bst_len, bst_addr));
        wait_accept();
        flush_pulse();
        drain();

        // R7 flush with nothing open
        flush_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!bst_valid && wr_ready,
                $sformatf("R7 idle flush valid %b ready %b exp 0 1", bst_valid, wr_ready));
            tick();
        end
        flush_req = 1'b0;

        // R8 timeout exact
        wr(16'h0080, 32'h80808080, 4'hF, 1'b1);
        for (int k = 1; k <= 15; k++) tick();
        @(negedge clk);
        chk(!bst_valid, $sformatf("R8 early timeout valid %b exp 0", bst_valid));
        tick();
        @(negedge clk);
        chk(bst_valid && bst_addr == 16'h0080,
            $sformatf("R8 timeout valid %b addr %h exp 1 0080", bst_valid, bst_addr));
        drain();

        // R8 store on the expiring edge wins
        wr(16'h00C0, 32'hC0C0C0C0, 4'hF, 1'b1);
        for (int k = 1; k <= 15; k++) tick();
        wr(16'h00C1, 32'hC1C1C1C1, 4'hF, 1'b1);
        @(negedge clk);
        chk(!bst_valid, $sformatf("R8 timeout beat store valid %b exp 0", bst_valid));
        flush_pulse();
        @(negedge clk);
        chk(bst_valid && bst_len == 4'd2,
            $sformatf("R8 merged after restart len %0d exp 2", bst_len));
        drain();

        // random streams
        rnd_ready = 1'b1;
        cur = 16'h0100;
        for (int n = 0; n < 400; n++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 25)      cur = cur;
            else if (r < 65) cur = cur + 16'd1;
            else if (r < 85) cur = 16'($urandom % 512);
            else             cur = cur - 16'd1;
            if ($urandom % 20 == 0) flush_pulse();
            wr(cur, $urandom, 4'($urandom), ($urandom % 8) != 0);
            if ($urandom % 30 == 0) begin
                for (int g = 0; g < 14 + int'($urandom % 4); g++) tick();
            end else begin
                for (int g = 0; g < int'($urandom % 3); g++) tick();
            end
        end
        flush_pulse();
        rnd_ready = 1'b0;
        #2;
        drain();
        repeat (10) tick();
        @(negedge clk);
        chk(q.size() == 0 && !m_open && !bst_valid,
            $sformatf("R3 leftover bursts %0d open %b exp 0 0", q.size(), m_open));

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule